// File: doc/BRIEF.md
# Self-Triggered Segment Buffer Manager

This block manages a sample store split into fixed-length segments so that a fast sampling front end can keep capturing short windows of a waveform while earlier windows are still being drained. Each trigger that finds the block idle and a segment free claims the next segment in circular order. It stores the sample present on the trigger cycle and the samples of the following cycles into that segment, and it records the value of a free-running cycle counter as a coarse time tag.

Completed segments form a queue. The reader drains them oldest first over a valid/ready stream, and a level flag tells it that work is waiting. The reader may also discard the segment at the head of the queue without reading it, which returns that segment to the free pool at once. Capture and readout run on the same clock and never block each other. The only limits are that a trigger arriving during a capture is ignored, and a trigger arriving when every segment is held is counted as lost.

With the default parameters the store holds 128 segments of 32 samples each, 4096 samples in total, with 12-bit samples and a 32-bit time tag.

Top module: `segbuf_ctrl`

## Requirements
- R1: After reset `data_avail` and `rd_valid` are low, `lost_count` is 0 and the first segment claimed has index 0.
- R2: A trigger accepted on a given clock edge stores the `smp_in` value sampled on that edge as sample 0 of the segment, and the values on the next SEG_LEN-1 edges as samples 1 to SEG_LEN-1.
- R3: The time tag of a segment is the value of a 32-bit counter that reads 0 on the first edge after reset is released and rises by one on every edge, taken on the edge that accepts the trigger.
- R4: A trigger on any of the SEG_LEN-1 edges after an accepted trigger is ignored: it claims nothing and does not change `lost_count`.
- R5: A trigger while the block is not capturing and all NUM_SEG segments are held (captured, being captured or queued) is dropped and raises `lost_count` by one, saturating at 65535.
- R6: `data_avail` is high exactly while at least one fully captured segment has not been read out or skipped; a segment counts from the edge that writes its last sample.
- R7: A segment is read as SEG_LEN+1 beats: first a header beat with `rd_first`=1 and the time tag on `rd_data`, then the samples in capture order, zero-extended, with `rd_last`=1 only on the final sample; `rd_seg` gives the segment index on every beat.
- R8: A beat is consumed only on an edge with `rd_valid` and `rd_ready` high; while `rd_ready` is low all read outputs hold.
- R9: Segments are delivered in the order their triggers were accepted, and segment indices follow 0, 1, ..., NUM_SEG-1, 0.
- R10: `skip_req` while `data_avail` is high frees the head segment on that edge, whatever beat it is on, and takes priority over a handshake on the same edge; the next beat is the header of the following segment. With no segment waiting, `skip_req` has no effect.
- R11: Triggers are accepted while a readout is in progress, as long as a segment is free.
- R12: A segment freed by readout or skip can be claimed again, so the block never holds more than NUM_SEG segments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and readout clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_in | input | 12 | Sample value presented on every cycle |
| trig_in | input | 1 | Self-trigger request |
| rd_ready | input | 1 | Reader accepts the current beat |
| skip_req | input | 1 | Discard the head segment |
| rd_valid | output | 1 | A beat is offered |
| rd_first | output | 1 | Current beat is the header (time tag) |
| rd_last | output | 1 | Current beat is the final sample |
| rd_seg | output | 7 | Index of the segment being read |
| rd_data | output | 32 | Time tag on the header beat, zero-extended sample otherwise |
| data_avail | output | 1 | At least one captured segment is waiting |
| lost_count | output | 16 | Saturating count of triggers dropped for lack of space |

## Verification
On every cycle the assertions check that no claim happens during a capture, that the block never holds more segments than it has, that the lost counter steps by one on a drop, stays put otherwise and sticks at its ceiling, that a finished capture raises the waiting flag, that read outputs hold under backpressure, that a skip with data waiting always frees a segment, and that the read index advances by one, wrapping, after each release. The sample contents, the exact time tags, the edge on which data becomes visible, the boundary edge at which a second trigger is first accepted, and in-order delivery of a fully occupied store refilled during readout can only be shown by the bench's scenarios, which compute every sample from the cycle on which it was presented.

// File: rtl/segbuf_pkg.sv
package segbuf_pkg;

  // Circular successor of an index in a pool of n entries.
  function automatic int wrap_next(int p, int n);
    return (p >= n - 1) ? 0 : p + 1;
  endfunction

  // Linear cell position of sample pos inside segment seg.
  function automatic int cell_addr(int seg, int pos, int seg_len);
    return seg * seg_len + pos;
  endfunction

  // Increment that stops at a ceiling.
  function automatic int sat_inc(int v, int ceil_v);
    return (v >= ceil_v) ? ceil_v : v + 1;
  endfunction

endpackage

// File: rtl/segbuf_dpram.sv
module segbuf_dpram #(
  parameter int W     = 12,
  parameter int DEPTH = 4096,
  parameter int AW    = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/segbuf_writer.sv
module segbuf_writer
  import segbuf_pkg::*;
#(
  parameter int NUM_SEG  = 128,
  parameter int SEG_LEN  = 32,
  parameter int SAMPLE_W = 12,
  parameter int TS_W     = 32,
  parameter int LOST_W   = 16,
  parameter int IDX_W    = 7,
  parameter int POS_W    = 5,
  parameter int ADDR_W   = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                trig_in,
  input  logic                full,
  input  logic [SAMPLE_W-1:0] smp_in,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_waddr,
  output logic [SAMPLE_W-1:0] mem_wdata,
  output logic                ts_we,
  output logic [IDX_W-1:0]    ts_waddr,
  output logic [TS_W-1:0]     ts_wdata,
  output logic                claim,
  output logic                drop,
  output logic                seg_done,
  output logic                busy,
  output logic [LOST_W-1:0]   lost_count
);

  localparam int LOST_MAX = (1 << LOST_W) - 1;

  logic [TS_W-1:0]   ts_cnt;
  logic [POS_W-1:0]  wcnt;
  logic [IDX_W-1:0]  wr_ptr;
  logic [POS_W-1:0]  pos;

  assign claim    = trig_in && !busy && !full;
  assign drop     = trig_in && !busy && full;
  assign pos      = busy ? wcnt : '0;
  assign seg_done = busy && (wcnt == POS_W'(SEG_LEN - 1));

  assign mem_we    = claim || busy;
  assign mem_waddr = ADDR_W'(cell_addr(int'(wr_ptr), int'(pos), SEG_LEN));
  assign mem_wdata = smp_in;

  assign ts_we    = claim;
  assign ts_waddr = wr_ptr;
  assign ts_wdata = ts_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts_cnt     <= '0;
      busy       <= 1'b0;
      wcnt       <= '0;
      wr_ptr     <= '0;
      lost_count <= '0;
    end else begin
      ts_cnt <= ts_cnt + 1'b1;
      if (claim) begin
        busy <= 1'b1;
        wcnt <= POS_W'(1);
      end else if (busy) begin
        wcnt <= wcnt + 1'b1;
        if (seg_done) begin
          busy   <= 1'b0;
          wr_ptr <= IDX_W'(wrap_next(int'(wr_ptr), NUM_SEG));
        end
      end
      if (drop) lost_count <= LOST_W'(sat_inc(int'(lost_count), LOST_MAX));
    end
  end

endmodule

// File: rtl/segbuf_reader.sv
module segbuf_reader
  import segbuf_pkg::*;
#(
  parameter int NUM_SEG  = 128,
  parameter int SEG_LEN  = 32,
  parameter int SAMPLE_W = 12,
  parameter int TS_W     = 32,
  parameter int IDX_W    = 7,
  parameter int ADDR_W   = 12,
  parameter int BEAT_W   = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                avail,
  input  logic                rd_ready,
  input  logic                skip_req,
  input  logic [SAMPLE_W-1:0] smp_rdata,
  input  logic [TS_W-1:0]     ts_rdata,
  output logic [ADDR_W-1:0]   smp_raddr,
  output logic [IDX_W-1:0]    ts_raddr,
  output logic                rd_valid,
  output logic                rd_first,
  output logic                rd_last,
  output logic [IDX_W-1:0]    rd_seg,
  output logic [TS_W-1:0]     rd_data,
  output logic                release_seg
);

  logic [BEAT_W-1:0] beat;
  logic [IDX_W-1:0]  rd_ptr;
  logic              skip_take;
  logic              xfer;
  int                spos;

  assign rd_valid = avail;
  assign rd_first = (beat == '0);
  assign rd_last  = (beat == BEAT_W'(SEG_LEN));
  assign rd_seg   = rd_ptr;

  assign spos      = rd_first ? 0 : int'(beat) - 1;
  assign smp_raddr = ADDR_W'(cell_addr(int'(rd_ptr), spos, SEG_LEN));
  assign ts_raddr  = rd_ptr;
  assign rd_data   = rd_first ? ts_rdata : TS_W'(smp_rdata);

  assign skip_take   = skip_req && avail;
  assign xfer        = avail && rd_ready && !skip_req;
  assign release_seg = skip_take || (xfer && rd_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat   <= '0;
      rd_ptr <= '0;
    end else if (release_seg) begin
      beat   <= '0;
      rd_ptr <= IDX_W'(wrap_next(int'(rd_ptr), NUM_SEG));
    end else if (xfer) begin
      beat <= beat + 1'b1;
    end
  end

endmodule

// File: rtl/segbuf_ctrl.sv
module segbuf_ctrl #(
  parameter int NUM_SEG  = 128,
  parameter int SEG_LEN  = 32,
  parameter int SAMPLE_W = 12,
  parameter int TS_W     = 32,
  parameter int LOST_W   = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [SAMPLE_W-1:0]           smp_in,
  input  logic                          trig_in,
  input  logic                          rd_ready,
  input  logic                          skip_req,
  output logic                          rd_valid,
  output logic                          rd_first,
  output logic                          rd_last,
  output logic [$clog2(NUM_SEG)-1:0]    rd_seg,
  output logic [TS_W-1:0]               rd_data,
  output logic                          data_avail,
  output logic [LOST_W-1:0]             lost_count
);

  localparam int IDX_W  = $clog2(NUM_SEG);
  localparam int POS_W  = $clog2(SEG_LEN);
  localparam int ADDR_W = $clog2(NUM_SEG * SEG_LEN);
  localparam int CNT_W  = $clog2(NUM_SEG + 1);
  localparam int BEAT_W = $clog2(SEG_LEN + 1);

  // Named internal events, also observed by the bound checker.
  logic              claim_evt, drop_evt, done_evt, release_evt, wr_busy;
  logic [CNT_W-1:0]  alloc_cnt, done_cnt;
  logic              full;

  logic                mem_we, ts_we;
  logic [ADDR_W-1:0]   mem_waddr, smp_raddr;
  logic [SAMPLE_W-1:0] mem_wdata, smp_rdata;
  logic [IDX_W-1:0]    ts_waddr, ts_raddr;
  logic [TS_W-1:0]     ts_wdata, ts_rdata;

  assign full       = (alloc_cnt == CNT_W'(NUM_SEG));
  assign data_avail = (done_cnt != '0);

  // alloc_cnt: segments claimed and not yet released.
  // done_cnt : segments fully captured and not yet released.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alloc_cnt <= '0;
      done_cnt  <= '0;
    end else begin
      alloc_cnt <= alloc_cnt + CNT_W'(claim_evt) - CNT_W'(release_evt);
      done_cnt  <= done_cnt + CNT_W'(done_evt) - CNT_W'(release_evt);
    end
  end

  segbuf_writer #(
    .NUM_SEG(NUM_SEG), .SEG_LEN(SEG_LEN), .SAMPLE_W(SAMPLE_W), .TS_W(TS_W),
    .LOST_W(LOST_W), .IDX_W(IDX_W), .POS_W(POS_W), .ADDR_W(ADDR_W)
  ) u_writer (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .full(full), .smp_in(smp_in),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .ts_we(ts_we), .ts_waddr(ts_waddr), .ts_wdata(ts_wdata),
    .claim(claim_evt), .drop(drop_evt), .seg_done(done_evt), .busy(wr_busy),
    .lost_count(lost_count)
  );

  segbuf_dpram #(.W(SAMPLE_W), .DEPTH(NUM_SEG * SEG_LEN), .AW(ADDR_W)) u_smp_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(smp_raddr), .rdata(smp_rdata)
  );

  segbuf_dpram #(.W(TS_W), .DEPTH(NUM_SEG), .AW(IDX_W)) u_ts_mem (
    .clk(clk), .we(ts_we), .waddr(ts_waddr), .wdata(ts_wdata),
    .raddr(ts_raddr), .rdata(ts_rdata)
  );

  segbuf_reader #(
    .NUM_SEG(NUM_SEG), .SEG_LEN(SEG_LEN), .SAMPLE_W(SAMPLE_W), .TS_W(TS_W),
    .IDX_W(IDX_W), .ADDR_W(ADDR_W), .BEAT_W(BEAT_W)
  ) u_reader (
    .clk(clk), .rst_n(rst_n), .avail(data_avail), .rd_ready(rd_ready),
    .skip_req(skip_req), .smp_rdata(smp_rdata), .ts_rdata(ts_rdata),
    .smp_raddr(smp_raddr), .ts_raddr(ts_raddr), .rd_valid(rd_valid),
    .rd_first(rd_first), .rd_last(rd_last), .rd_seg(rd_seg), .rd_data(rd_data),
    .release_seg(release_evt)
  );

endmodule

// File: rtl/segbuf_checker.sv
module segbuf_checker #(
  parameter int NUM_SEG = 128,
  parameter int TS_W    = 32,
  parameter int LOST_W  = 16,
  parameter int IDX_W   = 7,
  parameter int CNT_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              claim,
  input logic              drop,
  input logic              seg_done,
  input logic              release_seg,
  input logic              wr_busy,
  input logic [CNT_W-1:0]  alloc_cnt,
  input logic [CNT_W-1:0]  done_cnt,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic              skip_req,
  input logic              rd_first,
  input logic              rd_last,
  input logic [IDX_W-1:0]  rd_seg,
  input logic [TS_W-1:0]   rd_data,
  input logic              data_avail,
  input logic [LOST_W-1:0] lost_count
);

  localparam logic [LOST_W-1:0] LOST_TOP = '1;

  a_r4_no_claim_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy |-> !claim);

  a_r5_lost_step: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && lost_count != LOST_TOP) |=> lost_count == $past(lost_count) + 1'b1);

  a_r5_lost_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_count == LOST_TOP) |=> lost_count == LOST_TOP);

  a_r4_lost_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !drop |=> $stable(lost_count));

  a_r12_claim_has_room: assert property (@(posedge clk) disable iff (!rst_n)
    claim |-> alloc_cnt < CNT_W'(NUM_SEG));

  a_r6_queue_within_pool: assert property (@(posedge clk) disable iff (!rst_n)
    done_cnt <= alloc_cnt);

  a_r6_done_then_avail: assert property (@(posedge clk) disable iff (!rst_n)
    seg_done |=> data_avail);

  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !skip_req) |=>
      (rd_valid && $stable(rd_seg) && $stable(rd_data) && $stable(rd_first) && $stable(rd_last)));

  a_r7_header_not_last: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !(rd_first && rd_last));

  a_r10_skip_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_req && data_avail) |-> release_seg);

  a_r9_index_advances: assert property (@(posedge clk) disable iff (!rst_n)
    release_seg |=> rd_seg == IDX_W'(segbuf_pkg::wrap_next(int'($past(rd_seg)), NUM_SEG)));

endmodule

bind segbuf_ctrl segbuf_checker #(
  .NUM_SEG(NUM_SEG), .TS_W(TS_W), .LOST_W(LOST_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .claim(claim_evt), .drop(drop_evt), .seg_done(done_evt),
  .release_seg(release_evt), .wr_busy(wr_busy), .alloc_cnt(alloc_cnt),
  .done_cnt(done_cnt), .rd_valid(rd_valid), .rd_ready(rd_ready), .skip_req(skip_req),
  .rd_first(rd_first), .rd_last(rd_last), .rd_seg(rd_seg), .rd_data(rd_data),
  .data_avail(data_avail), .lost_count(lost_count)
);

// File: tb/test_segbuf_ctrl.sv
module test_segbuf_ctrl;

  localparam int NS = 128;
  localparam int SL = 32;
  localparam int SW = 12;
  localparam int TW = 32;
  localparam int LW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [SW-1:0] smp_in;
  logic          trig_in, rd_ready, skip_req;
  logic          rd_valid, rd_first, rd_last, data_avail;
  logic [6:0]    rd_seg;
  logic [TW-1:0] rd_data;
  logic [LW-1:0] lost_count;

  always #10 clk = ~clk;

  segbuf_ctrl i_segbuf_ctrl (
    .clk(clk), .rst_n(rst_n), .smp_in(smp_in), .trig_in(trig_in),
    .rd_ready(rd_ready), .skip_req(skip_req), .rd_valid(rd_valid),
    .rd_first(rd_first), .rd_last(rd_last), .rd_seg(rd_seg), .rd_data(rd_data),
    .data_avail(data_avail), .lost_count(lost_count)
  );

  // Bench cycle count: edges since reset release.
  int tb_cyc;
  always_ff @(posedge clk) begin
    if (!rst_n) tb_cyc <= 0;
    else        tb_cyc <= tb_cyc + 1;
  end

  function automatic logic [SW-1:0] smp_at(int c);
    return SW'(c * 37 + 5);
  endfunction

  initial begin
    smp_in = '0;
    forever begin
      @(negedge clk);
      smp_in = smp_at(tb_cyc);
    end
  end

  int n_cmp = 0;
  int n_bad = 0;
  int q_ts[$];
  int q_seg[$];
  int nxt_seg = 0;
  bit rpat = 1'b0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // Called at a negedge; trigger is seen on the next edge.
  task automatic fire(bit accept);
    trig_in = 1'b1;
    if (accept) begin
      q_ts.push_back(tb_cyc);
      q_seg.push_back(nxt_seg);
      nxt_seg = (nxt_seg + 1) % NS;
    end
    @(negedge clk);
    trig_in = 1'b0;
  endtask

  // Read the head segment; skip_after >= 0 issues a skip after that many beats.
  task automatic read_seg(int skip_after);
    int e_ts, e_seg, beat;
    longint exp;
    e_ts  = q_ts.pop_front();
    e_seg = q_seg.pop_front();
    beat  = 0;
    while (beat <= SL) begin
      if (skip_after >= 0 && beat == skip_after) begin
        while (!rd_valid) @(negedge clk);
        skip_req = 1'b1;
        rd_ready = 1'b1;
        @(negedge clk);
        skip_req = 1'b0;
        rd_ready = 1'b0;
        break;
      end
      rd_ready = rpat ? ((tb_cyc % 4) != 3) : 1'b1;
      if (rd_ready && rd_valid) begin
        if (beat == 0) begin
          chk(rd_seg == 7'(e_seg), "R9 R12 segment index", rd_seg, e_seg);
          chk(rd_data == TW'(e_ts), "R3 time tag", rd_data, e_ts);
          chk(rd_first && !rd_last, "R7 header flags", {rd_first, rd_last}, 2);
        end else begin
          exp = longint'(smp_at(e_ts + beat - 1));
          chk(longint'(rd_data) == exp, rpat ? "R8 sample under stall" : "R2 sample",
              rd_data, exp);
          chk(!rd_first && (rd_last == (beat == SL)), "R7 sample flags",
              {rd_first, rd_last}, (beat == SL) ? 1 : 0);
        end
        beat++;
      end
      @(negedge clk);
    end
    rd_ready = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; trig_in = 1'b0; rd_ready = 1'b0; skip_req = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(!data_avail, "R1 data_avail", data_avail, 0);
    chk(!rd_valid, "R1 rd_valid", rd_valid, 0);
    chk(lost_count == 0, "R1 lost_count", lost_count, 0);
    step(1);

    // R4 / R6: trigger during capture ignored, boundary of acceptance
    fire(1'b1);            // segment 0
    step(3);
    fire(1'b0);            // mid-capture, ignored
    step(26);
    chk(!data_avail, "R6 not before last sample", data_avail, 0);
    fire(1'b0);            // on the last capture edge, ignored
    chk(data_avail, "R6 after last sample", data_avail, 1);
    fire(1'b1);            // first free edge, accepted: segment 1
    chk(lost_count == 0, "R4 ignored triggers not lost", lost_count, 0);
    read_seg(-1);
    read_seg(-1);
    step(40);
    chk(!data_avail, "R4 no extra segment", data_avail, 0);

    // R5 / R12: fill every segment with readout stalled
    for (int i = 0; i < NS; i++) begin
      fire(1'b1);
      step(SL - 1);
    end
    chk(data_avail, "R6 full store waiting", data_avail, 1);
    fire(1'b0);
    fire(1'b0);
    fire(1'b0);
    chk(lost_count == 3, "R5 drops counted", lost_count, 3);
    trig_in = 1'b1;
    step(65540);
    trig_in = 1'b0;
    step(1);
    chk(lost_count == 16'hFFFF, "R5 saturation", lost_count, 65535);

    // R11 / R9 / R12: drain under backpressure while new triggers arrive
    rpat = 1'b1;
    read_seg(-1);
    fork
      begin
        for (int i = 0; i < NS + 2; i++) read_seg(-1);
      end
      begin
        for (int k = 0; k < 3; k++) begin
          fire(1'b1);
          step(63);
        end
      end
    join
    chk(lost_count == 16'hFFFF, "R11 triggers accepted during readout", lost_count, 65535);
    step(2);
    chk(!data_avail, "R6 empty after drain", data_avail, 0);

    // R10: skip mid-segment, skip at header with handshake, skip when empty
    rpat = 1'b0;
    for (int k = 0; k < 3; k++) begin
      fire(1'b1);
      step(SL - 1);
    end
    step(2);
    read_seg(2);
    read_seg(0);
    read_seg(-1);
    step(1);
    chk(!data_avail, "R10 skipped segments freed", data_avail, 0);
    skip_req = 1'b1;
    step(1);
    skip_req = 1'b0;
    fire(1'b1);
    step(SL + 1);
    chk(data_avail, "R10 empty skip has no effect", data_avail, 1);
    read_seg(-1);
    step(1);
    chk(!data_avail, "R10 final drain", data_avail, 0);

    summary();
    $finish;
  end

endmodule